// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Aggregation

This block manages several banks of general-purpose pins behind one 32-bit register port. Each bank has its own 32-byte register window that holds per-pin output value, direction, open-drain enable and the interrupt configuration for that bank. Software reads and writes these registers to drive pins, sample them, and choose for each pin whether it raises events on a level, a single edge or both edges.

Pin inputs are resynchronised before any detection. Detected events latch into a per-bank pending register, and software clears it by writing ones. Each bank compares its pending bits with an enable register, and the requests of all banks merge into a single interrupt line. Pad drivers and the bus bridge sit outside the block: the block only produces output values and output-enable vectors.

Top module: `banked_gpio_irq`

## Requirements
- R1: Bank b occupies byte addresses b*0x20 to b*0x20+0x1C. The word offsets within a bank are 0x00 open-drain enable, 0x04 output data, 0x08 direction, 0x0C rise select, 0x10 both-edge select, 0x14 interrupt enable, 0x18 level select and 0x1C pending. Each register other than data and pending reads back the value last written in its low BANK_WIDTH bits.
- R2: A read is requested by holding reg_re high on a rising edge. reg_rdata shows the result after that edge and holds it until the next read. Bits at or above BANK_WIDTH read 0. A bank index at or above NUM_BANKS reads 0, and writes to it change nothing.
- R3: A direction bit of 1 makes the pin an input with pin_oe low. A bit of 0 makes it an output. For a push-pull output, pin_oe is high and pin_out equals the data bit.
- R4: An output pin whose open-drain bit is 1 has pin_out held at 0 and drives only when its data bit is 0: pin_oe is the inverse of the data bit.
- R5: A data register read returns the synchronised pin input for input pins and the written data bit for output pins. An input change made before edge k is visible to a read sampled at edge k+3 or later.
- R6: When a pin's level bit is 1, its pending bit is set on every cycle that the synchronised input is high. A clear written while the input stays high leaves it set.
- R7: When the level bit is 0 and the both-edge bit is 1, both rising and falling input edges set the pending bit, and the rise select bit has no effect.
- R8: When the level bit and the both-edge bit are both 0, a rise select bit of 1 detects rising edges only and a rise select bit of 0 detects falling edges only.
- R9: An input change made between edges k-1 and k sets its pending bit, and a masked irq, at edge k+2, not earlier.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Without a write, pending bits never fall. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R11: irq is high whenever any bank has a pending bit that is also enabled. It follows the register state with no added delay. Disabling an enable drops irq but keeps the pending bit.
- R12: After reset, every register is 0 except direction, which is all ones (all pins inputs). pin_oe is therefore 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address: bank index above bit 5, word offset in bits 4:2 |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_re | input | 1 | Read strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*BANK_WIDTH | Pin inputs, bank b pin i at index b*BANK_WIDTH+i |
| pin_out | output | NUM_BANKS*BANK_WIDTH | Pin output values |
| pin_oe | output | NUM_BANKS*BANK_WIDTH | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the edge that samples reg_we, so pin_out, pin_oe and irq are checked at the falling edge that follows. Read data is due one edge after reg_re and is sampled at the next falling edge. Pin events take three edges to reach the pending register: two synchroniser stages, then the latch. The bench drives pin changes on a falling edge and checks irq low after the second following edge and high after the third. The same-cycle clear is timed so its write edge is exactly the third edge after a pin toggle.

// File: rtl/gpio_pkg.sv
// Shared constants and the register offset encoding for the banked GPIO block.
// Assumes 32-bit registers on word boundaries and a 32-byte window per bank.
package gpio_pkg;

    localparam int REG_W     = 32;
    localparam int WIN_BYTES = 32;
    localparam int OFF_W     = 3;

    // Word offset inside a bank window (byte offset / 4)
    typedef enum logic [OFF_W-1:0] {
        OFF_ODRAIN  = 3'd0,
        OFF_DOUT    = 3'd1,
        OFF_DIR     = 3'd2,
        OFF_RISESEL = 3'd3,
        OFF_ANYEDGE = 3'd4,
        OFF_IEN     = 3'd5,
        OFF_LVL     = 3'd6,
        OFF_PEND    = 3'd7
    } reg_off_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser plus one history stage for a vector of pin inputs.
// Assumes pins are asynchronous to clk; each bit is treated independently.
module gpio_in_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Resynchronise pins and keep the previous synchronised value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
// Per-pin event qualifier: level-high, both-edge, rising or falling.
// Assumes sync/prev come from consecutive cycles of the synchroniser.
// Priority: level select, then both-edge select, then rise select.
module gpio_evt_detect #(
    parameter int W = 24
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] anyedge_i,
    input  logic [W-1:0] risesel_i,
    output logic [W-1:0] evt_o
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        // Raw edge terms for this pin
        assign rise_w = sync_i[i] & ~prev_i[i];
        assign fall_w = ~sync_i[i] & prev_i[i];
        // Select the event source from the pin's configuration
        assign evt_o[i] = lvl_i[i]     ? sync_i[i] :
                          anyedge_i[i] ? (rise_w | fall_w) :
                          risesel_i[i] ? rise_w : fall_w;
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// Register file and pin drive for one bank.
// Assumes the caller qualifies wr_en with the bank decode; reads are
// combinational and registered by the top.
module gpio_bank_regs
    import gpio_pkg::*;
#(
    parameter int W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W-1:0]     sync_i,
    input  logic [W-1:0]     evt_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [W-1:0]     lvl_o,
    output logic [W-1:0]     anyedge_o,
    output logic [W-1:0]     risesel_o,
    output logic [W-1:0]     pend_o,
    output logic [W-1:0]     pin_out_o,
    output logic [W-1:0]     pin_oe_o,
    output logic             req_o
);

    logic [W-1:0] odrain_q, dout_q, dir_q, risesel_q;
    logic [W-1:0] anyedge_q, ien_q, lvl_q, pend_q;
    logic [W-1:0] clr_w;
    logic [W-1:0] din_view_w;

    // Configuration registers, written as whole words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odrain_q  <= '0;
            dout_q    <= '0;
            dir_q     <= '1;
            risesel_q <= '0;
            anyedge_q <= '0;
            ien_q     <= '0;
            lvl_q     <= '0;
        end else if (wr_en) begin
            case (off_i)
                OFF_ODRAIN:  odrain_q  <= wdata_i;
                OFF_DOUT:    dout_q    <= wdata_i;
                OFF_DIR:     dir_q     <= wdata_i;
                OFF_RISESEL: risesel_q <= wdata_i;
                OFF_ANYEDGE: anyedge_q <= wdata_i;
                OFF_IEN:     ien_q     <= wdata_i;
                OFF_LVL:     lvl_q     <= wdata_i;
                default:     ;
            endcase
        end
    end

    // Clear vector from a write to the pending offset
    assign clr_w = (wr_en && off_i == OFF_PEND) ? wdata_i : '0;

    // Pending register: write-one-to-clear, a new event overrides a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_w) | evt_i;
    end

    // Data view: input pins show the pad, output pins show the written value
    assign din_view_w = (dir_q & sync_i) | (~dir_q & dout_q);

    // Read mux, zero-extended to the register width
    always_comb begin
        case (off_i)
            OFF_ODRAIN:  rdata_o = REG_W'(odrain_q);
            OFF_DOUT:    rdata_o = REG_W'(din_view_w);
            OFF_DIR:     rdata_o = REG_W'(dir_q);
            OFF_RISESEL: rdata_o = REG_W'(risesel_q);
            OFF_ANYEDGE: rdata_o = REG_W'(anyedge_q);
            OFF_IEN:     rdata_o = REG_W'(ien_q);
            OFF_LVL:     rdata_o = REG_W'(lvl_q);
            default:     rdata_o = REG_W'(pend_q);
        endcase
    end

    // Pin drive: open-drain outputs only pull low
    assign pin_out_o = dout_q & ~odrain_q;
    assign pin_oe_o  = ~dir_q & (~odrain_q | ~dout_q);

    assign lvl_o     = lvl_q;
    assign anyedge_o = anyedge_q;
    assign risesel_o = risesel_q;
    assign pend_o    = pend_q;
    assign req_o     = |(pend_q & ien_q);

endmodule

// File: rtl/banked_gpio_irq.sv
// Top of the banked GPIO controller: address decode, per-bank generate,
// registered read port and interrupt merge.
// Assumes BANK_WIDTH <= 32 and single-cycle write/read strobes.
module banked_gpio_irq
    import gpio_pkg::*;
#(
    parameter  int NUM_BANKS  = 3,
    parameter  int BANK_WIDTH = 24,
    localparam int BIDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BIDX_W + $clog2(WIN_BYTES),
    localparam int PINS       = NUM_BANKS * BANK_WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);

    localparam int OFF_LSB = $clog2(WIN_BYTES) - OFF_W;

    logic [BIDX_W-1:0] bidx_w;
    logic [OFF_W-1:0]  off_w;
    logic [REG_W-1:0]  bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_req;
    logic [PINS-1:0]   pend_all;
    logic [REG_W-1:0]  rd_mux;

    // Split the byte address into bank index and word offset
    assign bidx_w = reg_addr[ADDR_W-1 -: BIDX_W];
    assign off_w  = reg_addr[OFF_LSB +: OFF_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_WIDTH-1:0] sync_w, prev_w, evt_w;
        logic [BANK_WIDTH-1:0] lvl_w, anyedge_w, risesel_w, pend_w;
        logic                  wr_w;

        // Write qualification for this bank
        assign wr_w = reg_we && (bidx_w == BIDX_W'(b));

        gpio_in_sync #(.W(BANK_WIDTH)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pad_in (pin_in[b*BANK_WIDTH +: BANK_WIDTH]),
            .sync_o (sync_w),
            .prev_o (prev_w)
        );

        gpio_evt_detect #(.W(BANK_WIDTH)) u_evt (
            .sync_i    (sync_w),
            .prev_i    (prev_w),
            .lvl_i     (lvl_w),
            .anyedge_i (anyedge_w),
            .risesel_i (risesel_w),
            .evt_o     (evt_w)
        );

        gpio_bank_regs #(.W(BANK_WIDTH)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_w),
            .off_i     (off_w),
            .wdata_i   (reg_wdata[BANK_WIDTH-1:0]),
            .sync_i    (sync_w),
            .evt_i     (evt_w),
            .rdata_o   (bank_rd[b]),
            .lvl_o     (lvl_w),
            .anyedge_o (anyedge_w),
            .risesel_o (risesel_w),
            .pend_o    (pend_w),
            .pin_out_o (pin_out[b*BANK_WIDTH +: BANK_WIDTH]),
            .pin_oe_o  (pin_oe[b*BANK_WIDTH +: BANK_WIDTH]),
            .req_o     (bank_req[b])
        );

        assign pend_all[b*BANK_WIDTH +: BANK_WIDTH] = pend_w;
    end

    // Select the addressed bank's read word; unmapped banks give zero
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bidx_w == BIDX_W'(b)) rd_mux = bank_rd[b];
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_mux;
    end

    // One interrupt line for all banks
    assign irq = |bank_req;

endmodule

// File: rtl/gpio_chk.sv
// Assertion checker for banked_gpio_irq, attached by bind below.
// Assumes synchronous active-low reset and the port semantics of the top.
module gpio_chk #(
    parameter  int NUM_BANKS  = 3,
    parameter  int BANK_WIDTH = 24,
    localparam int BIDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BIDX_W + 5,
    localparam int PINS       = NUM_BANKS * BANK_WIDTH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              reg_re,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pend_all,
    input logic              irq
);

    AST_IRQ_OFF_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq); // R12

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && (int'(reg_addr[ADDR_W-1 -: BIDX_W]) >= NUM_BANKS)) |=> (reg_rdata == 32'd0)); // R2

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata)); // R2

    AST_DIR_INPUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(8) && (&reg_wdata[BANK_WIDTH-1:0]))
        |=> (pin_oe[BANK_WIDTH-1:0] == '0)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((pend_all & $past(pend_all)) == $past(pend_all))); // R10

endmodule

bind banked_gpio_irq gpio_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_WIDTH (BANK_WIDTH)
) u_gpio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_oe    (pin_oe),
    .pend_all  (pend_all),
    .irq       (irq)
);

// File: tb/test_banked_gpio_irq.sv
module test_banked_gpio_irq;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 3;
    localparam int BW   = 24;
    localparam int AW   = 7;
    localparam int PINS = NB * BW;
    localparam logic [31:0] WMASK = 32'h00FF_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic            reg_we = 1'b0;
    logic            reg_re = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;
    logic            irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_gpio_irq #(.NUM_BANKS(NB), .BANK_WIDTH(BW)) i_banked_gpio_irq (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [AW-1:0] adr(int bank, int off);
        return AW'(bank * 32 + off);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pin(int idx, logic v);
        @(negedge clk);
        pin_in[idx] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] bitof(logic [31:0] w, int i);
        return {31'd0, w[i]};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        check("R12 pin_oe", 32'(pin_oe[31:0]), 32'd0);
        check("R12 irq", {31'd0, irq}, 32'd0);
        rd(adr(0, 8'h08), d);  check("R12 dir all inputs", d, WMASK);
        rd(adr(2, 8'h14), d);  check("R12 enable zero", d, 32'd0);
        rd(adr(1, 8'h1C), d);  check("R12 pending zero", d, 32'd0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        int offs[5] = '{8'h00, 8'h0C, 8'h10, 8'h14, 8'h18};
        foreach (offs[k]) begin
            wr(adr(1, offs[k]), 32'hA5A5_A5A5);
            rd(adr(1, offs[k]), d);
            check("R1 readback, R2 upper bits zero", d, 32'h00A5_A5A5);
            wr(adr(1, offs[k]), 32'd0);
        end
        wr(adr(1, 8'h08), 32'd0);
        rd(adr(1, 8'h08), d);      check("R1 dir readback", d, 32'd0);
        wr(adr(1, 8'h04), 32'hFFFF_FFFF);
        rd(adr(1, 8'h04), d);      check("R1 data readback", d, WMASK);
        wr(adr(1, 8'h04), 32'd0);
        wr(adr(1, 8'h08), 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(adr(3, 8'h14), d);      check("R2 unmapped read", d, 32'd0);
        rd(adr(0, 8'h08), d);
        idle(2);
        check("R2 rdata held", reg_rdata, WMASK);
        wr(adr(3, 8'h08), 32'd0);
        check("R2 unmapped write ignored", 32'(pin_oe[31:0]), 32'd0);
    endtask

    task automatic t_drive;
        wr(adr(0, 8'h08), 32'h00FF_FFF0);
        wr(adr(0, 8'h04), 32'h0000_0005);
        check("R3 oe push-pull", {28'd0, pin_oe[3:0]}, 32'hF);
        check("R3 out push-pull", {28'd0, pin_out[3:0]}, 32'h5);
        wr(adr(0, 8'h00), 32'h0000_000F);
        check("R4 oe open-drain", {28'd0, pin_oe[3:0]}, 32'hA);
        check("R4 out open-drain", {28'd0, pin_out[3:0]}, 32'h0);
    endtask

    task automatic t_din;
        logic [31:0] d;
        pin(8, 1'b1);
        idle(2);
        rd(adr(0, 8'h04), d);
        check("R5 data view", d, 32'h0000_0105);
    endtask

    task automatic t_rise;
        logic [31:0] d;
        wr(adr(0, 8'h0C), 32'h1 << 10);
        wr(adr(0, 8'h14), 32'h1 << 10);
        pin(10, 1'b1);
        idle(2);
        check("R9 not before third edge", {31'd0, irq}, 32'd0);
        idle(1);
        check("R9 irq at third edge", {31'd0, irq}, 32'd1);
        wr(adr(0, 8'h1C), 32'h1 << 10);
        check("R11 irq drops after clear", {31'd0, irq}, 32'd0);
        pin(10, 1'b0);
        idle(4);
        rd(adr(0, 8'h1C), d);
        check("R8 falling ignored in rise mode", bitof(d, 10), 32'd0);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        pin(11, 1'b1);
        idle(4);
        rd(adr(0, 8'h1C), d);      check("R8 rising ignored in fall mode", bitof(d, 11), 32'd0);
        pin(11, 1'b0);
        idle(4);
        rd(adr(0, 8'h1C), d);      check("R8 falling detected", bitof(d, 11), 32'd1);
        wr(adr(0, 8'h1C), 32'h1 << 11);
    endtask

    task automatic t_both;
        logic [31:0] d;
        wr(adr(0, 8'h10), 32'h1 << 12);
        pin(12, 1'b1);
        idle(4);
        rd(adr(0, 8'h1C), d);      check("R7 rise in both-edge", bitof(d, 12), 32'd1);
        wr(adr(0, 8'h1C), 32'h1 << 12);
        pin(12, 1'b0);
        idle(4);
        rd(adr(0, 8'h1C), d);      check("R7 fall in both-edge", bitof(d, 12), 32'd1);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        // bit 12 is pending; write zero first
        wr(adr(0, 8'h1C), 32'd0);
        rd(adr(0, 8'h1C), d);      check("R10 zero write keeps", bitof(d, 12), 32'd1);
        // toggle pin so its event edge coincides with a clear
        pin(12, 1'b1);
        @(negedge clk);
        @(negedge clk);
        reg_addr = adr(0, 8'h1C); reg_wdata = 32'h1 << 12; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(adr(0, 8'h1C), d);      check("R10 event wins over clear", bitof(d, 12), 32'd1);
        wr(adr(0, 8'h1C), 32'h1 << 12);
        rd(adr(0, 8'h1C), d);      check("R10 clear by one", bitof(d, 12), 32'd0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(adr(0, 8'h18), 32'h1 << 13);
        pin(13, 1'b1);
        idle(4);
        rd(adr(0, 8'h1C), d);      check("R6 level sets", bitof(d, 13), 32'd1);
        wr(adr(0, 8'h1C), 32'h1 << 13);
        rd(adr(0, 8'h1C), d);      check("R6 clear while high stays", bitof(d, 13), 32'd1);
        pin(13, 1'b0);
        idle(3);
        wr(adr(0, 8'h1C), 32'h1 << 13);
        rd(adr(0, 8'h1C), d);      check("R6 clear after low", bitof(d, 13), 32'd0);
    endtask

    task automatic t_multibank;
        logic [31:0] d;
        pin(2*BW + 5, 1'b1);
        idle(4);
        pin(2*BW + 5, 1'b0);
        idle(4);
        check("R11 no irq while disabled", {31'd0, irq}, 32'd0);
        wr(adr(2, 8'h14), 32'h1 << 5);
        check("R11 irq from bank 2", {31'd0, irq}, 32'd1);
        wr(adr(2, 8'h14), 32'd0);
        check("R11 irq off when disabled", {31'd0, irq}, 32'd0);
        rd(adr(2, 8'h1C), d);      check("R11 pending kept", bitof(d, 5), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_unmapped;
        t_drive;
        t_din;
        t_rise;
        t_fall;
        t_both;
        t_w1c;
        t_level;
        t_multibank;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule